// File: doc/BRIEF.md
# Three-Wire Serial EEPROM Slave

This block is the device side of a three-wire serial memory link: chip select, serial clock and data in come from a host, and the block returns data out with an output-enable. Behind the link sits a storage array of 256 words of 16 bits. The array is built from flops and resets to the erased state, where every bit is 1. The host clocks in fixed 11-bit instruction frames. Each frame is a start bit of 1, a 2-bit opcode and an 8-bit address. The block decodes the frame and reads a word, writes a word, erases a word, erases the whole array, writes the whole array, or switches the write guard on or off.

Every modifying instruction starts a self-timed programming cycle. The cycle lasts `PROG_CYCLES` periods of the free-running system clock. While chip select is high after the cycle has started, data out shows readiness: 0 while the cycle runs and 1 once it has finished. A read returns one leading zero bit and then the word, most significant bit first. If the host keeps clocking, the block streams the following words and moves up through the addresses. All serial inputs are sampled in the system clock domain, and the block acts on rising edges of the serial clock.

Top module: `mw_eeprom`

## Requirements
- R1: With chip select high, 0 bits on data in before a frame are skipped. A frame begins at the first 1, and the 2 opcode bits and 8 address bits that follow are taken most significant bit first.
- R2: After reset the write guard is closed. While it is closed, write, erase, erase-all and write-all change no word and start no programming cycle.
- R3: Opcode 00 with address bits [7:6] = 11 opens the write guard. Opcode 00 with address bits [7:6] = 00 closes it.
- R4: Opcode 01 takes 16 further data bits, most significant bit first, and stores them in the addressed word.
- R5: Opcode 11 sets the addressed word to 16'hFFFF. Opcode 00 with bits [7:6] = 10 sets every word to 16'hFFFF. Opcode 00 with bits [7:6] = 01 takes 16 data bits and stores them in every word.
- R6: Opcode 10 drives a 0 on data out at the rising serial clock edge of the last address bit. The next 16 rising edges drive the addressed word, most significant bit first, and data out changes only on those edges.
- R7: If clocking continues after a word has been read, the next rising edge starts the word at the address plus one, with no extra leading zero. Address 255 is followed by address 0.
- R8: A programming cycle lasts PROG_CYCLES system clock cycles. While it runs and chip select is high, data out is driven to 0. After it ends, data out is driven to 1 until chip select falls or a new frame starts.
- R9: While a programming cycle runs, start bits are ignored, so no instruction given during that time takes effect.
- R10: Dropping chip select discards a partial frame and releases data out (output-enable low). It does not stop a programming cycle that is already running.
- R11: The serial clock may pause for any length of time inside a frame or a read stream, and the transfer resumes with no loss.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Free-running system clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cs | input | 1 | Chip select, active high |
| sck | input | 1 | Serial clock from the host |
| din | input | 1 | Serial data in |
| dout | output | 1 | Serial data out: read data or ready/busy |
| dout_oe | output | 1 | High when dout is driven, low for high impedance |

## Verification
The bench builds the block with the full 8-bit, 16-bit organisation and a programming time of 200 system clocks. At that length a complete instruction can be sent while a cycle is still running, which tests that start bits are ignored when busy. The cycle is also short enough that dozens of writes, word erases and whole-array operations fit in one run. With 256 words, the address wrap from 255 to 0 during a streamed read is reached by a directed test, and random addresses cover the rest of the array.

// File: rtl/mw_eeprom_pkg.sv
package mw_eeprom_pkg;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_CMD   = 2'd1,
        ST_WDATA = 2'd2,
        ST_READ  = 2'd3
    } mw_state_e;

    localparam logic [1:0] OP_EXT   = 2'b00;
    localparam logic [1:0] OP_WRITE = 2'b01;
    localparam logic [1:0] OP_READ  = 2'b10;
    localparam logic [1:0] OP_ERASE = 2'b11;

    localparam logic [1:0] SUB_LOCK   = 2'b00;
    localparam logic [1:0] SUB_FILL   = 2'b01;
    localparam logic [1:0] SUB_CLEAR  = 2'b10;
    localparam logic [1:0] SUB_UNLOCK = 2'b11;

endpackage

// File: rtl/mw_sck_edge.sv
module mw_sck_edge (
    input  logic clk,
    input  logic rst_n,
    input  logic sck,
    output logic rise
);
    logic sck_d, sck_q;

    always_comb begin
        sck_d = sck;
        rise  = sck & ~sck_q;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sck_q <= 1'b0;
        else        sck_q <= sck_d;
    end
endmodule

// File: rtl/mw_prog_timer.sv
module mw_prog_timer #(
    parameter int CYCLES = 5000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    output logic busy
);
    localparam int CW = $clog2(CYCLES + 1);

    logic [CW-1:0] cnt_d, cnt_q;

    always_comb begin
        if (start)              cnt_d = CW'(CYCLES);
        else if (cnt_q != '0)   cnt_d = cnt_q - 1'b1;
        else                    cnt_d = cnt_q;
        busy = (cnt_q != '0);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end
endmodule

// File: rtl/mw_word_array.sv
module mw_word_array #(
    parameter int ADDR_W = 8,
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              we,
    input  logic              all,
    input  logic [ADDR_W-1:0] waddr,
    input  logic [DATA_W-1:0] wdata,
    input  logic [ADDR_W-1:0] raddr,
    output logic [DATA_W-1:0] rdata
);
    localparam int DEPTH = 1 << ADDR_W;

    logic [DATA_W-1:0] mem_d [DEPTH];
    logic [DATA_W-1:0] mem_q [DEPTH];

    always_comb begin
        for (int i = 0; i < DEPTH; i++) begin
            if (we && (all || waddr == ADDR_W'(i))) mem_d[i] = wdata;
            else                                     mem_d[i] = mem_q[i];
        end
        rdata = mem_q[raddr];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) mem_q[i] <= '1;
        end else begin
            for (int i = 0; i < DEPTH; i++) mem_q[i] <= mem_d[i];
        end
    end
endmodule

// File: rtl/mw_eeprom.sv
module mw_eeprom
    import mw_eeprom_pkg::*;
#(
    parameter int ADDR_W      = 8,
    parameter int DATA_W      = 16,
    parameter int PROG_CYCLES = 5000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic cs,
    input  logic sck,
    input  logic din,
    output logic dout,
    output logic dout_oe
);
    localparam int FRAME_W = 2 + ADDR_W;
    localparam int CNT_W   = $clog2(DATA_W + FRAME_W + 1);
    localparam int BIT_W   = $clog2(DATA_W);

    typedef struct packed {
        mw_state_e         state;
        logic [CNT_W-1:0]  cnt;
        logic [FRAME_W-2:0] frame;
        logic [DATA_W-2:0] wshift;
        logic              wall;
        logic [ADDR_W-1:0] addr;
        logic [DATA_W-1:0] rword;
        logic [BIT_W-1:0]  ridx;
        logic              wen;
        logic              status;
        logic              dbit;
        logic              oe;
    } ctl_t;

    ctl_t d, q;

    logic              sck_rise;
    logic              prog_start;
    logic              busy;
    logic              arr_we;
    logic              arr_all;
    logic [ADDR_W-1:0] arr_waddr;
    logic [ADDR_W-1:0] arr_raddr;
    logic [DATA_W-1:0] arr_wdata;
    logic [DATA_W-1:0] arr_rdata;

    logic [FRAME_W-1:0] frame_next;
    logic [DATA_W-1:0]  wdata_next;
    logic [1:0]         op;
    logic [ADDR_W-1:0]  faddr;
    logic [1:0]         sub;
    logic [ADDR_W-1:0]  inc_addr;

    mw_sck_edge u_edge (
        .clk  (clk),
        .rst_n(rst_n),
        .sck  (sck),
        .rise (sck_rise)
    );

    mw_prog_timer #(.CYCLES(PROG_CYCLES)) u_timer (
        .clk  (clk),
        .rst_n(rst_n),
        .start(prog_start),
        .busy (busy)
    );

    mw_word_array #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_array (
        .clk  (clk),
        .rst_n(rst_n),
        .we   (arr_we),
        .all  (arr_all),
        .waddr(arr_waddr),
        .wdata(arr_wdata),
        .raddr(arr_raddr),
        .rdata(arr_rdata)
    );

    always_comb begin
        frame_next = {q.frame, din};
        wdata_next = {q.wshift, din};
        op         = frame_next[FRAME_W-1 -: 2];
        faddr      = frame_next[ADDR_W-1:0];
        sub        = faddr[ADDR_W-1 -: 2];
        inc_addr   = q.addr + 1'b1;
        arr_raddr  = (q.state == ST_READ) ? inc_addr : faddr;
    end

    always_comb begin
        d          = q;
        prog_start = 1'b0;
        arr_we     = 1'b0;
        arr_all    = 1'b0;
        arr_waddr  = q.addr;
        arr_wdata  = wdata_next;

        if (!cs) begin
            d.state = ST_IDLE;
            d.cnt   = '0;
            if (!busy) d.status = 1'b0;
        end else if (sck_rise) begin
            case (q.state)
                ST_IDLE: begin
                    if (din && !busy) begin
                        d.state  = ST_CMD;
                        d.cnt    = '0;
                        d.status = 1'b0;
                    end
                end
                ST_CMD: begin
                    d.frame = frame_next[FRAME_W-2:0];
                    d.cnt   = q.cnt + 1'b1;
                    if (q.cnt == CNT_W'(FRAME_W - 1)) begin
                        d.cnt   = '0;
                        d.addr  = faddr;
                        d.state = ST_IDLE;
                        case (op)
                            OP_READ: begin
                                d.state = ST_READ;
                                d.rword = arr_rdata;
                                d.ridx  = BIT_W'(DATA_W - 1);
                                d.dbit  = 1'b0;
                            end
                            OP_WRITE: begin
                                d.state = ST_WDATA;
                                d.wall  = 1'b0;
                            end
                            OP_ERASE: begin
                                if (q.wen) begin
                                    arr_we     = 1'b1;
                                    arr_waddr  = faddr;
                                    arr_wdata  = '1;
                                    prog_start = 1'b1;
                                    d.status   = 1'b1;
                                end
                            end
                            default: begin
                                case (sub)
                                    SUB_UNLOCK: d.wen = 1'b1;
                                    SUB_LOCK:   d.wen = 1'b0;
                                    SUB_CLEAR: begin
                                        if (q.wen) begin
                                            arr_we     = 1'b1;
                                            arr_all    = 1'b1;
                                            arr_wdata  = '1;
                                            prog_start = 1'b1;
                                            d.status   = 1'b1;
                                        end
                                    end
                                    default: begin
                                        d.state = ST_WDATA;
                                        d.wall  = 1'b1;
                                    end
                                endcase
                            end
                        endcase
                    end
                end
                ST_WDATA: begin
                    d.wshift = wdata_next[DATA_W-2:0];
                    d.cnt    = q.cnt + 1'b1;
                    if (q.cnt == CNT_W'(DATA_W - 1)) begin
                        d.cnt   = '0;
                        d.state = ST_IDLE;
                        if (q.wen) begin
                            arr_we     = 1'b1;
                            arr_all    = q.wall;
                            prog_start = 1'b1;
                            d.status   = 1'b1;
                        end
                    end
                end
                default: begin
                    d.dbit = q.rword[q.ridx];
                    if (q.ridx == '0) begin
                        d.addr  = inc_addr;
                        d.rword = arr_rdata;
                        d.ridx  = BIT_W'(DATA_W - 1);
                    end else begin
                        d.ridx = q.ridx - 1'b1;
                    end
                end
            endcase
        end

        d.oe = cs && ((d.state == ST_READ) || (d.state == ST_IDLE && d.status));
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q       <= '0;
            q.state <= ST_IDLE;
        end else begin
            q <= d;
        end
    end

    always_comb begin
        dout_oe = q.oe;
        if (q.state == ST_IDLE && q.status) dout = ~busy;
        else                                dout = q.dbit;
    end
endmodule

// File: rtl/mw_eeprom_chk.sv
module mw_eeprom_chk
    import mw_eeprom_pkg::*;
#(
    parameter int PROG_CYCLES = 5000
) (
    input logic      clk,
    input logic      rst_n,
    input logic      cs,
    input logic      sck,
    input logic      dout,
    input logic      dout_oe,
    input logic      busy,
    input logic      wen,
    input mw_state_e state
);
    int busy_len;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)    busy_len <= 0;
        else if (busy) busy_len <= busy_len + 1;
        else           busy_len <= 0;
    end

    assert_busy_length_R8: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> busy_len == PROG_CYCLES);

    assert_prog_needs_guard_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> wen);

    assert_no_frame_while_busy_R9: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> state == ST_IDLE);

    assert_release_on_cs_low_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !cs |=> !dout_oe);

    assert_read_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_READ && cs && $stable(sck)) |=> $stable(dout));
endmodule

bind mw_eeprom mw_eeprom_chk #(.PROG_CYCLES(PROG_CYCLES)) u_chk (
    .clk    (clk),
    .rst_n  (rst_n),
    .cs     (cs),
    .sck    (sck),
    .dout   (dout),
    .dout_oe(dout_oe),
    .busy   (busy),
    .wen    (q.wen),
    .state  (q.state)
);

// File: tb/tb_mw_eeprom.sv
module tb_mw_eeprom;
    localparam int CLK_PERIOD = 10;
    localparam int PROG       = 200;
    localparam int WATCHDOG   = 150000;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic cs = 1'b0;
    logic sck = 1'b0;
    logic din = 1'b0;
    logic dout, dout_oe;

    int n_chk = 0;
    int n_fail = 0;
    logic samp_d, samp_oe;
    logic [15:0] mdl [256];
    bit mwen;

    mw_eeprom #(.ADDR_W(8), .DATA_W(16), .PROG_CYCLES(PROG)) dut (
        .clk(clk), .rst_n(rst_n), .cs(cs), .sck(sck), .din(din),
        .dout(dout), .dout_oe(dout_oe)
    );

    always #(CLK_PERIOD / 2) clk = ~clk;

    function automatic logic [15:0] exp_word(input logic [7:0] a);
        return mdl[a];
    endfunction

    task automatic summary();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    endtask

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic sbit(input logic b);
        @(negedge clk); din = b; sck = 1'b1;
        @(negedge clk); @(negedge clk); sck = 1'b0;
        @(negedge clk); samp_d = dout; samp_oe = dout_oe;
    endtask

    task automatic cs_up();
        @(negedge clk); cs = 1'b1;
    endtask

    task automatic cs_down();
        @(negedge clk); cs = 1'b0;
        @(negedge clk); @(negedge clk);
    endtask

    task automatic send_cmd(input logic [1:0] op, input logic [7:0] a);
        sbit(1'b1);
        for (int i = 1; i >= 0; i--) sbit(op[i]);
        for (int i = 7; i >= 0; i--) sbit(a[i]);
    endtask

    task automatic send_data(input logic [15:0] w);
        for (int i = 15; i >= 0; i--) sbit(w[i]);
    endtask

    task automatic wait_ready(input string req);
        int n = 0;
        chk({req, " busy shown"}, {30'd0, samp_oe, samp_d}, 32'd2);
        while (dout === 1'b0 && n < PROG + 20) begin
            @(negedge clk); n++;
        end
        chk("R8 ready after cycle", {31'd0, dout}, 32'd1);
        chk("R8 busy length", (n >= PROG - 4 && n <= PROG) ? 32'd1 : 32'd0, 32'd1);
    endtask

    task automatic do_write(input logic [7:0] a, input logic [15:0] w);
        cs_up(); send_cmd(2'b01, a); send_data(w);
        if (mwen) begin mdl[a] = w; wait_ready("R4"); end
        else chk("R2 ignored write no status", {31'd0, samp_oe}, 32'd0);
        cs_down();
    endtask

    task automatic do_erase(input logic [7:0] a);
        cs_up(); send_cmd(2'b11, a);
        if (mwen) begin mdl[a] = 16'hFFFF; wait_ready("R5"); end
        else chk("R2 ignored erase no status", {31'd0, samp_oe}, 32'd0);
        cs_down();
    endtask

    task automatic do_eral();
        cs_up(); send_cmd(2'b00, 8'h95);
        if (mwen) begin
            for (int i = 0; i < 256; i++) mdl[i] = 16'hFFFF;
            wait_ready("R5");
        end else chk("R2 ignored erase-all", {31'd0, samp_oe}, 32'd0);
        cs_down();
    endtask

    task automatic do_wral(input logic [15:0] w);
        cs_up(); send_cmd(2'b00, 8'h4A); send_data(w);
        if (mwen) begin
            for (int i = 0; i < 256; i++) mdl[i] = w;
            wait_ready("R5");
        end else chk("R2 ignored write-all", {31'd0, samp_oe}, 32'd0);
        cs_down();
    endtask

    task automatic do_guard(input bit en);
        cs_up(); send_cmd(2'b00, en ? 8'hC3 : 8'h2C); cs_down();
        mwen = en;
    endtask

    task automatic do_read_x(input logic [7:0] a, input int nw, input int lead,
                             input int pause, input string req);
        logic [15:0] w;
        cs_up();
        for (int i = 0; i < lead; i++) sbit(1'b0);
        sbit(1'b1);
        sbit(1'b1); sbit(1'b0);
        for (int i = 7; i >= 0; i--) begin
            sbit(a[i]);
            if (i == 4) repeat (pause) @(negedge clk);
        end
        chk({req, " leading zero"}, {30'd0, samp_oe, samp_d}, 32'd2);
        for (int k = 0; k < nw; k++) begin
            w = '0;
            for (int i = 0; i < 16; i++) begin
                sbit(1'b0);
                w = {w[14:0], samp_d};
                if (k == 0 && i == 5) repeat (pause) @(negedge clk);
            end
            chk(k == 0 ? req : "R7 next word", {16'd0, w}, {16'd0, exp_word(8'(a + k))});
        end
        cs_down();
    endtask

    task automatic do_read(input logic [7:0] a, input int nw, input string req);
        do_read_x(a, nw, 0, 0, req);
    endtask

    initial begin
        repeat (WATCHDOG) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        summary();
        $finish;
    end

    initial begin
        for (int i = 0; i < 256; i++) mdl[i] = 16'hFFFF;
        mwen = 0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R10 output released after reset", {31'd0, dout_oe}, 32'd0);

        do_read(8'h00, 1, "R6");
        do_write(8'h05, 16'h1234);
        do_read(8'h05, 1, "R2");
        do_eral();
        do_guard(1'b1);
        do_write(8'h05, 16'h1234);
        do_read(8'h05, 1, "R3");
        do_read_x(8'h05, 1, 3, 0, "R1");
        do_write(8'hFF, 16'hBEEF);
        do_write(8'h00, 16'h0BAD);
        do_read(8'hFF, 3, "R7");
        do_erase(8'h05);
        do_read(8'h05, 1, "R5");

        // R9: a full erase frame sent during a running cycle has no effect
        cs_up(); send_cmd(2'b01, 8'h0A); send_data(16'h1111); mdl[8'h0A] = 16'h1111;
        send_cmd(2'b11, 8'h0A);
        chk("R9 still busy after ignored frame", {31'd0, dout}, 32'd0);
        while (dout === 1'b0) @(negedge clk);
        cs_down();
        do_read(8'h0A, 1, "R9");

        // R10: dropping cs does not stop programming
        cs_up(); send_cmd(2'b01, 8'h20); send_data(16'h5A5A); mdl[8'h20] = 16'h5A5A;
        cs_down();
        chk("R10 released while cs low", {31'd0, dout_oe}, 32'd0);
        cs_up(); @(negedge clk); @(negedge clk);
        chk("R10 cycle continues across cs drop", {30'd0, dout_oe, dout}, 32'd2);
        while (dout === 1'b0) @(negedge clk);
        cs_down();
        do_read(8'h20, 1, "R10");

        // R10: partial write frame is discarded
        cs_up(); send_cmd(2'b01, 8'h20);
        for (int i = 0; i < 8; i++) sbit(1'b0);
        cs_down();
        do_read(8'h20, 1, "R10");

        // R11: long clock pauses inside address and data
        do_read_x(8'h20, 2, 0, 700, "R11");

        do_wral(16'hA5C3);
        do_read(8'h77, 2, "R5");
        do_guard(1'b0);
        do_write(8'h33, 16'h0000);
        do_read(8'h33, 1, "R3");
        do_guard(1'b1);

        void'($urandom(32'h5EED1234));
        for (int t = 0; t < 50; t++) begin
            int r;
            logic [7:0] a;
            r = int'($urandom % 12);
            a = 8'($urandom);
            case (r)
                0, 1, 2, 3: do_read(a, 1 + int'($urandom % 3), "R6");
                4, 5, 6:    do_write(a, 16'($urandom));
                7:          do_erase(a);
                8:          do_guard(1'b1);
                9:          do_guard(1'b0);
                10:         do_guard(1'b1);
                default: begin
                    if ($urandom % 2 == 0) do_wral(16'($urandom));
                    else                   do_eral();
                end
            endcase
        end

        summary();
        $finish;
    end
endmodule